// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches for a stalled processor. A 32-bit down-counter starts from a programmed reload value. When it first runs out, it raises an interrupt and starts again from the reload value. Software shows that it is alive by acknowledging that interrupt, which also restarts the count. If the count runs out a second time while the interrupt is still unacknowledged, the block asserts a system reset request. That request stays asserted until the block's own reset input is applied.

The block connects to a simple single-cycle register bus: a select and write strobe, a 12-bit byte address, 32-bit write data, and combinational read data. Every write goes through a lock. Software first writes a fixed 32-bit key to the lock register, changes the configuration, and then writes any other value to lock the registers again.

The reset input is asynchronous and active-low. Its release is expected to arrive already synchronized to the clock.

Top module: `wdt_twostage`

## Requirements
- R1: After reset, irq and sys_rst_req are low and the lock register reads 0 (unlocked). The reload register (offset 0x000) and the count register (0x004) read 0xFFFFFFFF. The control register (0x008) and the raw status register (0x010) read 0.
- R2: An accepted write to the reload register (0x000) stores the value and restarts the counter from it in the same clock. Reading 0x004 returns the live counter value.
- R3: The counter drops by one on each clock while control bit 0 (interrupt enable) is 1. It holds its value while that bit is 0, so writing 0 to control stops the watchdog.
- R4: On a clock where the counter is 0, counting is enabled and no interrupt is pending, the pending interrupt is set and the counter reloads from the reload register. From a reload value L, this happens on the (L+1)th clock.
- R5: On a clock where the counter is 0, counting is enabled, the interrupt is pending and control bit 1 (reset enable) is 1, sys_rst_req goes high. It then stays high until rst_n is asserted, whatever is written afterwards.
- R6: Under the conditions of R5 but with control bit 1 at 0, sys_rst_req stays low and the counter reloads from the reload register.
- R7: An accepted write of any value to the acknowledge register (0x00C) clears the pending interrupt and reloads the counter.
- R8: Bit 0 of the raw status register (0x010) shows the pending interrupt whatever the enables are. Bit 0 of the masked status register (0x014) is that bit ANDed with control bit 0, and the irq output equals the masked bit.
- R9: Writing 0x1ACCE551 to the lock register (0xC00) unlocks writes. Writing any other value there locks them. The lock register reads 1 while locked and 0 while unlocked.
- R10: While locked, writes to every address other than 0xC00 have no effect on the reload value, the control bits, the counter or the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per write |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Masked interrupt |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
The countdown is tried with small reload values, with an acknowledge arriving before the second expiry and with none arriving, so that a premature or late interrupt shows up as a one-cycle miss. The second expiry is run once with reset enabled and once with it disabled, which separates the reset path from the plain reload. The same writes are repeated locked and unlocked, which shows whether the key gates them. The run with the enable bit cleared separates the raw status from the masked status and from a frozen counter.

// File: rtl/wdt_twostage_pkg.sv
package wdt_twostage_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_RELOAD = 12'h000;
  localparam logic [AW-1:0] OFS_COUNT  = 12'h004;
  localparam logic [AW-1:0] OFS_CTRL   = 12'h008;
  localparam logic [AW-1:0] OFS_ACK    = 12'h00C;
  localparam logic [AW-1:0] OFS_RAW    = 12'h010;
  localparam logic [AW-1:0] OFS_MASKED = 12'h014;
  localparam logic [AW-1:0] OFS_LOCK   = 12'hC00;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
  } wd_ctrl_t;
endpackage

// File: rtl/wdt_twostage_regs.sv
module wdt_twostage_regs
  import wdt_twostage_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] reload_q,
  output wd_ctrl_t      ctrl_q,
  output logic          locked_q,
  output logic          restart,
  output logic [DW-1:0] restart_val,
  output logic          ack_wr
);
  logic          wr_any, wr_ok;
  logic          reload_en, ctrl_en, lock_en;
  logic [DW-1:0] reload_d;
  wd_ctrl_t      ctrl_d;
  logic          locked_d;

  always_comb begin
    wr_any    = bus_en && bus_we;
    wr_ok     = wr_any && !locked_q;
    lock_en   = wr_any && (bus_addr == OFS_LOCK);
    reload_en = wr_ok && (bus_addr == OFS_RELOAD);
    ctrl_en   = wr_ok && (bus_addr == OFS_CTRL);
    ack_wr    = wr_ok && (bus_addr == OFS_ACK);
    locked_d  = (bus_wdata != UNLOCK_KEY);
    reload_d  = bus_wdata;
    ctrl_d    = wd_ctrl_t'(bus_wdata[1:0]);
    restart   = reload_en || ack_wr;
    restart_val = reload_en ? bus_wdata : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (reload_en) reload_q <= reload_d;
      if (ctrl_en)   ctrl_q   <= ctrl_d;
      if (lock_en)   locked_q <= locked_d;
    end
  end

  p_locked_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_en && bus_we && bus_addr != OFS_LOCK)
      |=> ($stable(reload_q) && $stable(ctrl_q)));

  p_key_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == OFS_LOCK && bus_wdata == UNLOCK_KEY)
      |=> !locked_q);
endmodule

// File: rtl/wdt_twostage_core.sv
module wdt_twostage_core
  import wdt_twostage_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wd_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic             ack_wr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pend_q,
  output logic             rst_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             pend_d, rst_d;
  logic             expired;

  always_comb begin
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    rst_d   = rst_q;
    expired = ctrl.irq_en && (cnt_q == '0);
    if (restart) begin
      cnt_d = restart_val;
      if (ack_wr) pend_d = 1'b0;
    end else if (ctrl.irq_en) begin
      if (expired) begin
        cnt_d = reload_val;
        if (!pend_q)          pend_d = 1'b1;
        else if (ctrl.rst_en) rst_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      rst_q  <= rst_d;
    end
  end

  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.irq_en && !restart) |=> $stable(cnt_q));

  p_rst_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);

  p_rst_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(pend_q));

  p_rst_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(ctrl.rst_en));

  p_pend_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cnt_q == '0 && ctrl.irq_en));
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_twostage_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sys_rst_req
);
  logic [DW-1:0] reload_q, restart_val, cnt_q;
  wd_ctrl_t      ctrl_q;
  logic          locked_q, restart, ack_wr, pend_q, rst_q, masked;

  wdt_twostage_regs u_regs (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata,
    .reload_q, .ctrl_q, .locked_q, .restart, .restart_val, .ack_wr
  );

  wdt_twostage_core #(.CNT_W(DW)) u_core (
    .clk, .rst_n, .ctrl(ctrl_q), .reload_val(reload_q),
    .restart, .restart_val, .ack_wr, .cnt_q, .pend_q, .rst_q
  );

  always_comb begin
    masked    = pend_q && ctrl_q.irq_en;
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_RELOAD: bus_rdata = reload_q;
      OFS_COUNT:  bus_rdata = cnt_q;
      OFS_CTRL:   bus_rdata = {30'd0, ctrl_q};
      OFS_RAW:    bus_rdata = {31'd0, pend_q};
      OFS_MASKED: bus_rdata = {31'd0, masked};
      OFS_LOCK:   bus_rdata = {31'd0, locked_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign irq         = masked;
  assign sys_rst_req = rst_q;
endmodule

// File: tb/wdt_twostage_bench.sv
module wdt_twostage_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, sys_rst_req;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  wdt_twostage u_wdt_twostage (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst_req", sys_rst_req, 0);
    rd(12'h000, d); chk("R1 reload", d, 32'hFFFFFFFF);
    rd(12'h004, d); chk("R1 count", d, 32'hFFFFFFFF);
    rd(12'h008, d); chk("R1 ctrl", d, 0);
    rd(12'h010, d); chk("R1 raw", d, 0);
    rd(12'hC00, d); chk("R1 lock", d, 0);
  endtask

  task automatic t_count_hold();
    logic [31:0] d;
    do_reset();
    wr(12'h000, 10);
    rd(12'h000, d); chk("R2 reload stored", d, 10);
    wait_n(5);
    rd(12'h004, d); chk("R3 hold while disabled", d, 10);
    wr(12'h008, 1);
    wait_n(3);
    rd(12'h004, d); chk("R3 decrement when enabled", d, 7);
    wr(12'h008, 0);
    wait_n(4);
    rd(12'h004, d); chk("R3 control 0 stops count", d, 6);
    wr(12'h008, 1);
    wr(12'h000, 100);
    rd(12'h004, d); chk("R2 reload restarts count", d, 100);
    wait_n(4);
    rd(12'h004, d); chk("R2 live count", d, 96);
  endtask

  task automatic t_two_stage_reset();
    logic [31:0] d;
    do_reset();
    wr(12'h008, 3);
    wr(12'h000, 5);
    wait_n(5);
    chk("R4 no irq before expiry", irq, 0);
    wait_n(1);
    chk("R4 irq on first expiry", irq, 1);
    rd(12'h004, d); chk("R4 reload after expiry", d, 5);
    rd(12'h014, d); chk("R8 masked status", d, 1);
    wait_n(5);
    chk("R5 no reset before second expiry", sys_rst_req, 0);
    wait_n(1);
    chk("R5 reset on second expiry", sys_rst_req, 1);
    wr(12'h008, 0);
    wr(12'h00C, 0);
    wait_n(3);
    chk("R5 reset sticky", sys_rst_req, 1);
    do_reset();
    chk("R5 cleared by rst_n", sys_rst_req, 0);
  endtask

  task automatic t_no_reset_enable();
    logic [31:0] d;
    do_reset();
    wr(12'h008, 1);
    wr(12'h000, 3);
    wait_n(4);
    chk("R6 irq first expiry", irq, 1);
    wait_n(4);
    chk("R6 no reset when disabled", sys_rst_req, 0);
    rd(12'h004, d); chk("R6 reload on second expiry", d, 3);
    wr(12'h008, 0);
    rd(12'h010, d); chk("R8 raw kept with enable off", d, 1);
    rd(12'h014, d); chk("R8 masked off with enable off", d, 0);
    chk("R8 irq follows masked", irq, 0);
  endtask

  task automatic t_keepalive();
    logic [31:0] d;
    do_reset();
    wr(12'h008, 3);
    wr(12'h000, 5);
    wait_n(6);
    chk("R7 irq set", irq, 1);
    wr(12'h00C, 32'h12345678);
    chk("R7 ack clears irq", irq, 0);
    rd(12'h004, d); chk("R7 ack reloads", d, 5);
    for (int i = 0; i < 4; i++) begin
      wait_n(4);
      wr(12'h00C, 0);
    end
    chk("R7 kept alive no reset", sys_rst_req, 0);
    chk("R7 kept alive no irq", irq, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    wr(12'h008, 1);
    wr(12'h000, 2);
    wait_n(3);
    chk("R10 pending before lock", irq, 1);
    wr(12'hC00, 1);
    rd(12'hC00, d); chk("R9 lock reads 1", d, 1);
    wr(12'h000, 50);
    rd(12'h000, d); chk("R10 reload write ignored", d, 2);
    wr(12'h008, 0);
    rd(12'h008, d); chk("R10 ctrl write ignored", d, 1);
    wr(12'h00C, 0);
    rd(12'h010, d); chk("R10 ack ignored", d, 1);
    wr(12'hC00, KEY + 1);
    rd(12'hC00, d); chk("R9 wrong key stays locked", d, 1);
    wr(12'hC00, KEY);
    rd(12'hC00, d); chk("R9 key unlocks", d, 0);
    wr(12'h008, 0);
    wr(12'h000, 40);
    rd(12'h000, d); chk("R9 write accepted after unlock", d, 40);
  endtask

  initial begin
    t_reset_state();
    t_count_hold();
    t_two_stage_reset();
    t_no_reset_enable();
    t_keepalive();
    t_lock();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule